// File: doc/BRIEF.md
# Pixel Blink Transformation Unit

This block sits in a display pixel pipeline and makes selected pixels blink. A frame-rate blink phase is generated inside the block from a frame-start pulse and a programmable frame count. The phase alternates between an idle half and an active half. While the phase is active, each pixel that has its own blink-enable flag set is rewritten. Pixels without the flag, and all pixels seen during the idle half, leave the block untouched.

How a pixel is rewritten depends on the colour mode. In palette mode the pixel is an 8-bit table index. It is combined with a programmable mask by AND, OR or XOR, and the result feeds a colour table that lies outside this block. In the two direct-colour modes the table is not used, and the colour value itself is changed. It can be replaced by a background colour, dimmed, brightened or inverted. The modes are 5-6-5 bit 16-bit colour and 8-8-8 bit 24-bit colour.

The result appears one clock after the input, and the valid flag is delayed to match.

Top module: `pixel_blink_unit`

## Requirements
- R1: In palette mode (`color_mode`=0), a blinking pixel has its bits [7:0] replaced by `pixel[7:0]` combined with `blink_mask`. The operation is AND for `blink_op`=0, OR for 1 and XOR for 2. Bits [23:8] pass through unchanged.
- R2: In 16-bit mode (`color_mode`=1) or 24-bit mode (`color_mode`=2) with `blink_op`=3, a blinking pixel takes the background colour. In 24-bit mode all 24 bits come from `bg_color`. In 16-bit mode bits [15:0] come from `bg_color[15:0]` and bits [23:16] of the pixel are kept.
- R3: With `blink_op`=4 (dim), each colour component of a blinking direct-colour pixel is shifted right by one bit. In 24-bit mode the components are bits [23:16], [15:8] and [7:0]. In 16-bit mode they are [15:11], [10:5] and [4:0], and bits [23:16] are kept.
- R4: With `blink_op`=5 (bright), each component becomes its value shifted right by one with its top bit set. This uses the same component layout as R3, so the result never exceeds the component maximum.
- R5: With `blink_op`=6 (reverse), a blinking direct-colour pixel is bitwise inverted. All 24 bits are inverted in 24-bit mode; only bits [15:0] are inverted in 16-bit mode.
- R6: The pixel passes through unchanged in any of these cases: `pixel_blink_en` is 0, the blink phase is 0, `color_mode`=3, `blink_op`=7, a palette-mode pixel has an op of 3 to 6, or a direct-mode pixel has an op of 0 to 2.
- R7: Each `frame_start` pulse advances a frame counter. After `blink_frames` pulses (N) the phase toggles and the counter restarts. When N=0, a pulse forces the phase to 0.
- R8: `out_pixel` and `out_valid` follow the input with a latency of exactly one clock. `out_pixel` holds its value while `in_valid` is 0.
- R9: After a synchronous reset, `out_valid`, `out_pixel` and `blink_phase` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | One-cycle pulse at the start of each frame |
| blink_frames | input | 8 | Frames per blink half-period (0 holds the phase idle) |
| in_valid | input | 1 | Input pixel is valid |
| in_pixel | input | 24 | Palette index in [7:0], or direct colour |
| pixel_blink_en | input | 1 | This pixel takes part in blinking |
| color_mode | input | 2 | 0 palette, 1 16-bit, 2 24-bit, 3 reserved |
| blink_op | input | 3 | 0 AND, 1 OR, 2 XOR, 3 background, 4 dim, 5 bright, 6 reverse, 7 none |
| blink_mask | input | 8 | Mask for the palette operations |
| bg_color | input | 24 | Background colour for blink-to-background |
| out_valid | output | 1 | Output pixel is valid |
| out_pixel | output | 24 | Transformed table index or direct colour |
| blink_phase | output | 1 | Current blink phase (1 = active) |

## Verification
Several properties are checked by assertions on every cycle. These are the one-clock valid delay, unchanged output whenever a pixel is not blinking, full inversion in 24-bit reverse mode, phase stability between frame pulses, and the forced-idle phase when the frame count is zero. Other behaviour can only be shown by the bench's scenarios. This covers the exact arithmetic of dim and bright on the 5-6-5 and 8-8-8 layouts, the palette mask operations, and which mode and operation pairs are ignored. It also covers the frame count at which the phase toggles, and the reset state.

// File: rtl/blink_pkg.sv
package blink_pkg;

    localparam int unsigned PIX_W  = 24;
    localparam int unsigned IDX_W  = 8;
    localparam int unsigned COMP_W = 8;
    localparam int unsigned N_COMP = PIX_W / COMP_W;

    typedef enum logic [1:0] {
        CM_PALETTE = 2'd0,
        CM_RGB16   = 2'd1,
        CM_RGB24   = 2'd2,
        CM_RSVD    = 2'd3
    } color_mode_e;

    typedef enum logic [2:0] {
        BOP_AND     = 3'd0,
        BOP_OR      = 3'd1,
        BOP_XOR     = 3'd2,
        BOP_BACKGND = 3'd3,
        BOP_DIM     = 3'd4,
        BOP_BRIGHT  = 3'd5,
        BOP_REVERSE = 3'd6,
        BOP_NONE    = 3'd7
    } blink_op_e;

    typedef struct packed {
        logic             valid;
        logic [PIX_W-1:0] pixel;
    } pix_beat_t;

    // Halve a component.
    function automatic logic [COMP_W-1:0] comp_dim(input logic [COMP_W-1:0] c);
        return {1'b0, c[COMP_W-1:1]};
    endfunction

    // Halve a component and force its top bit, which can never overflow.
    function automatic logic [COMP_W-1:0] comp_bright(input logic [COMP_W-1:0] c);
        return {1'b1, c[COMP_W-1:1]};
    endfunction

endpackage

// File: rtl/blink_rate_gen.sv
module blink_rate_gen #(
    parameter int unsigned RATE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_start,
    input  logic [RATE_W-1:0] blink_frames,
    output logic              phase
);

    logic [RATE_W-1:0] frame_cnt;
    logic              at_limit;

    assign at_limit = (frame_cnt == blink_frames - RATE_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            frame_cnt <= '0;
            phase     <= 1'b0;
        end else if (frame_start) begin
            if (blink_frames == '0) begin
                frame_cnt <= '0;
                phase     <= 1'b0;
            end else if (at_limit || frame_cnt >= blink_frames) begin
                frame_cnt <= '0;
                phase     <= ~phase;
            end else begin
                frame_cnt <= frame_cnt + RATE_W'(1);
            end
        end
    end

    // R7: phase only moves on a frame pulse
    a_r7_phase_holds: assert property (@(posedge clk) disable iff (rst)
        !frame_start |=> $stable(phase));

    // R7: a zero frame count forces the idle phase
    a_r7_zero_rate_idle: assert property (@(posedge clk) disable iff (rst)
        (frame_start && blink_frames == '0) |=> !phase);

endmodule

// File: rtl/blink_pal_xform.sv
module blink_pal_xform
    import blink_pkg::*;
(
    input  logic [IDX_W-1:0] index,
    input  logic [IDX_W-1:0] mask,
    input  blink_op_e        op,
    output logic [IDX_W-1:0] index_out,
    output logic             hit
);

    always_comb begin
        hit       = 1'b1;
        index_out = index;
        unique case (op)
            BOP_AND: index_out = index & mask;
            BOP_OR:  index_out = index | mask;
            BOP_XOR: index_out = index ^ mask;
            default: hit = 1'b0;
        endcase
    end

endmodule

// File: rtl/blink_direct_xform.sv
module blink_direct_xform
    import blink_pkg::*;
(
    input  logic [PIX_W-1:0] pixel,
    input  logic [PIX_W-1:0] bg,
    input  blink_op_e        op,
    input  logic             is16,
    output logic [PIX_W-1:0] pixel_out,
    output logic             hit
);

    logic [PIX_W-1:0] dim24, bright24;
    logic [15:0]      dim16, bright16;

    // 8-8-8 layout: one lane per component
    for (genvar c = 0; c < N_COMP; c++) begin : g_comp
        assign dim24[c*COMP_W +: COMP_W]    = comp_dim(pixel[c*COMP_W +: COMP_W]);
        assign bright24[c*COMP_W +: COMP_W] = comp_bright(pixel[c*COMP_W +: COMP_W]);
    end

    // 5-6-5 layout
    assign dim16    = {1'b0, pixel[15:12], 1'b0, pixel[10:6], 1'b0, pixel[4:1]};
    assign bright16 = {1'b1, pixel[15:12], 1'b1, pixel[10:6], 1'b1, pixel[4:1]};

    always_comb begin
        hit       = 1'b1;
        pixel_out = pixel;
        unique case (op)
            BOP_BACKGND: pixel_out = is16 ? {pixel[23:16], bg[15:0]} : bg;
            BOP_DIM:     pixel_out = is16 ? {pixel[23:16], dim16}    : dim24;
            BOP_BRIGHT:  pixel_out = is16 ? {pixel[23:16], bright16} : bright24;
            BOP_REVERSE: pixel_out = is16 ? {pixel[23:16], ~pixel[15:0]} : ~pixel;
            default:     hit = 1'b0;
        endcase
    end

endmodule

// File: rtl/pixel_blink_unit.sv
module pixel_blink_unit
    import blink_pkg::*;
#(
    parameter int unsigned RATE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_start,
    input  logic [RATE_W-1:0] blink_frames,
    input  logic              in_valid,
    input  logic [PIX_W-1:0]  in_pixel,
    input  logic              pixel_blink_en,
    input  logic [1:0]        color_mode,
    input  logic [2:0]        blink_op,
    input  logic [IDX_W-1:0]  blink_mask,
    input  logic [PIX_W-1:0]  bg_color,
    output logic              out_valid,
    output logic [PIX_W-1:0]  out_pixel,
    output logic              blink_phase
);

    color_mode_e      mode;
    blink_op_e        op;
    logic [IDX_W-1:0] pal_res;
    logic             pal_hit;
    logic [PIX_W-1:0] dir_res;
    logic             dir_hit;
    pix_beat_t        nxt, stage;

    assign mode = color_mode_e'(color_mode);
    assign op   = blink_op_e'(blink_op);

    blink_rate_gen #(.RATE_W(RATE_W)) u_rate (
        .clk          (clk),
        .rst          (rst),
        .frame_start  (frame_start),
        .blink_frames (blink_frames),
        .phase        (blink_phase)
    );

    blink_pal_xform u_pal (
        .index     (in_pixel[IDX_W-1:0]),
        .mask      (blink_mask),
        .op        (op),
        .index_out (pal_res),
        .hit       (pal_hit)
    );

    blink_direct_xform u_dir (
        .pixel     (in_pixel),
        .bg        (bg_color),
        .op        (op),
        .is16      (mode == CM_RGB16),
        .pixel_out (dir_res),
        .hit       (dir_hit)
    );

    always_comb begin
        nxt.valid = in_valid;
        nxt.pixel = in_pixel;
        if (pixel_blink_en && blink_phase) begin
            unique case (mode)
                CM_PALETTE: if (pal_hit) nxt.pixel = {in_pixel[PIX_W-1:IDX_W], pal_res};
                CM_RGB16,
                CM_RGB24:   if (dir_hit) nxt.pixel = dir_res;
                default:    nxt.pixel = in_pixel;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stage <= '0;
        end else begin
            stage.valid <= nxt.valid;
            if (nxt.valid) stage.pixel <= nxt.pixel;
        end
    end

    assign out_valid = stage.valid;
    assign out_pixel = stage.pixel;

    // R8: valid is delayed by exactly one clock
    a_r8_valid_follows: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    a_r8_valid_drops: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    a_r8_hold_idle: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_pixel));

    // R6: non-blinking pixels leave unchanged
    a_r6_pass_idle: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (!pixel_blink_en || !blink_phase)) |=> out_pixel == $past(in_pixel));

    // R5: 24-bit reverse inverts every bit
    a_r5_reverse24: assert property (@(posedge clk) disable iff (rst)
        (in_valid && pixel_blink_en && blink_phase && color_mode == 2'd2 && blink_op == 3'd6)
        |=> out_pixel == ~$past(in_pixel));

endmodule

// File: tb/pixel_blink_unit_tb.sv
module pixel_blink_unit_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        frame_start;
    logic [7:0]  blink_frames;
    logic        in_valid;
    logic [23:0] in_pixel;
    logic        pixel_blink_en;
    logic [1:0]  color_mode;
    logic [2:0]  blink_op;
    logic [7:0]  blink_mask;
    logic [23:0] bg_color;
    logic        out_valid;
    logic [23:0] out_pixel;
    logic        blink_phase;

    int n_chk  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    pixel_blink_unit u_dut (
        .clk            (clk),
        .rst            (rst),
        .frame_start    (frame_start),
        .blink_frames   (blink_frames),
        .in_valid       (in_valid),
        .in_pixel       (in_pixel),
        .pixel_blink_en (pixel_blink_en),
        .color_mode     (color_mode),
        .blink_op       (blink_op),
        .blink_mask     (blink_mask),
        .bg_color       (bg_color),
        .out_valid      (out_valid),
        .out_pixel      (out_pixel),
        .blink_phase    (blink_phase)
    );

    // {mode, op, enable, pixel, expected}; mask 0F, background 123456, phase active
    localparam int NV = 16;
    localparam logic [53:0] VEC [NV] = '{
        {2'd0, 3'd0, 1'b1, 24'hABCDE7, 24'hABCD07},  // R1 AND
        {2'd0, 3'd1, 1'b1, 24'h000030, 24'h00003F},  // R1 OR
        {2'd0, 3'd2, 1'b1, 24'h0000A5, 24'h0000AA},  // R1 XOR
        {2'd2, 3'd3, 1'b1, 24'hFFEEDD, 24'h123456},  // R2 bg 24
        {2'd2, 3'd4, 1'b1, 24'h80FF02, 24'h407F01},  // R3 dim 24
        {2'd2, 3'd5, 1'b1, 24'h000000, 24'h808080},  // R4 bright 24
        {2'd2, 3'd5, 1'b1, 24'hFF1002, 24'hFF8881},  // R4 bright 24 saturate
        {2'd2, 3'd6, 1'b1, 24'h0F00F0, 24'hF0FF0F},  // R5 reverse 24
        {2'd1, 3'd4, 1'b1, 24'hAAFFFF, 24'hAA7BEF},  // R3 dim 16
        {2'd1, 3'd5, 1'b1, 24'h550000, 24'h558410},  // R4 bright 16
        {2'd1, 3'd6, 1'b1, 24'h331234, 24'h33EDCB},  // R5 reverse 16
        {2'd1, 3'd3, 1'b1, 24'h770000, 24'h773456},  // R2 bg 16
        {2'd0, 3'd4, 1'b1, 24'h000011, 24'h000011},  // R6 palette + direct op
        {2'd2, 3'd2, 1'b1, 24'h445566, 24'h445566},  // R6 direct + palette op
        {2'd2, 3'd6, 1'b0, 24'h0F0F0F, 24'h0F0F0F},  // R6 enable clear
        {2'd3, 3'd6, 1'b1, 24'h9ABCDE, 24'h9ABCDE}   // R6 reserved mode
    };

    task automatic chk(input string tag, input logic [23:0] act, input logic [23:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic frame_pulse();
        @(negedge clk) frame_start = 1'b1;
        @(negedge clk) frame_start = 1'b0;
    endtask

    task automatic send(input logic [1:0] m, input logic [2:0] o, input logic e,
                        input logic [23:0] p);
        @(negedge clk);
        in_valid = 1'b1; color_mode = m; blink_op = o; pixel_blink_en = e; in_pixel = p;
        @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1; frame_start = 1'b0; blink_frames = 8'd1; in_valid = 1'b0;
        in_pixel = 24'hFFFFFF; pixel_blink_en = 1'b0; color_mode = 2'd0; blink_op = 3'd7;
        blink_mask = 8'h0F; bg_color = 24'h123456;
        repeat (3) @(posedge clk);
        #1;
        chk("R9 out_valid", {23'd0, out_valid}, 24'd0);
        chk("R9 out_pixel", out_pixel, 24'd0);
        chk("R9 phase", {23'd0, blink_phase}, 24'd0);
        @(negedge clk) rst = 1'b0;

        // phase idle: blinking pixel passes (R6)
        send(2'd2, 3'd6, 1'b1, 24'h00FF00);
        chk("R6 phase idle", out_pixel, 24'h00FF00);
        chk("R8 valid one cycle", {23'd0, out_valid}, 24'd1);

        frame_pulse();
        chk("R7 toggle at N=1", {23'd0, blink_phase}, 24'd1);

        for (int i = 0; i < NV; i++) begin
            send(VEC[i][53:52], VEC[i][51:49], VEC[i][48], VEC[i][47:24]);
            chk($sformatf("vector %0d", i), out_pixel, VEC[i][23:0]);
        end

        send(2'd2, 3'd7, 1'b1, 24'h13579B);
        chk("R6 op none", out_pixel, 24'h13579B);

        // R8: hold and drop of valid
        @(negedge clk) begin in_valid = 1'b0; in_pixel = 24'h000001; end
        @(posedge clk); #1;
        chk("R8 valid drops", {23'd0, out_valid}, 24'd0);
        chk("R8 pixel holds", out_pixel, 24'h13579B);

        // R7: period of three frames
        frame_pulse();
        chk("R7 back to idle", {23'd0, blink_phase}, 24'd0);
        blink_frames = 8'd3;
        frame_pulse();
        frame_pulse();
        chk("R7 no toggle after 2 of 3", {23'd0, blink_phase}, 24'd0);
        frame_pulse();
        chk("R7 toggle after 3 of 3", {23'd0, blink_phase}, 24'd1);
        frame_pulse();
        chk("R7 hold after 1 of 3", {23'd0, blink_phase}, 24'd1);

        // R7: zero count forces idle
        blink_frames = 8'd0;
        frame_pulse();
        chk("R7 zero forces idle", {23'd0, blink_phase}, 24'd0);
        frame_pulse();
        chk("R7 zero stays idle", {23'd0, blink_phase}, 24'd0);
        send(2'd0, 3'd0, 1'b1, 24'h0000FF);
        chk("R6 idle after zero rate", out_pixel, 24'h0000FF);

        // R9: reset mid-stream
        @(negedge clk) begin rst = 1'b1; in_valid = 1'b1; end
        @(posedge clk); #1;
        chk("R9 reset clears pixel", out_pixel, 24'd0);
        chk("R9 reset clears valid", {23'd0, out_valid}, 24'd0);
        @(negedge clk) begin rst = 1'b0; in_valid = 1'b0; end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule